// File: doc/BRIEF.md
# Per-Core Highest-Priority Interrupt Selector

This block sits inside a small interrupt controller that serves several processor cores. For every core it looks at all interrupts that are both enabled and pending for that core. It picks the most urgent one, which is the one with the smallest priority number. It then decides two separate things. First, whether that winner is visible to the core as the pending ID. Second, whether the core's interrupt request line should be raised.

Two thresholds are applied. The winner is shown only if its priority is at or below the core's mask. The request line rises only if the winner is also strictly more urgent than the priority of the interrupt the core is already running.

Interrupts below 32 are private to each core and take their priority from a table kept for that core. Interrupts from 32 upward share one priority entry across all cores. The tables, the mask, the running priority and the enables are all inputs. Register access and acknowledge handling live outside this block. Both outputs are registered, so a change on any input appears on the outputs one clock later.

Top module: `irq_prio_select`

## Requirements
- R1: Among the interrupts that compete for a core, the winner is the one with the smallest 8-bit priority value; on equal priority the lower interrupt ID wins.
- R2: For interrupt IDs 0 to 31 the priority comes from that core's own private entry, `prio_private[(core*32+id)*8 +: 8]`; for IDs 32 and above it comes from the shared entry `prio_shared[(id-32)*8 +: 8]`, which is the same for every core.
- R3: An interrupt competes for a core only when both its enable bit and its pending bit for that core are 1, at bit `core*NUM_IRQ+id` of `irq_enable` and `irq_pending`; any other interrupt has no effect on that core's outputs.
- R4: A core's pending ID shows the winner's ID when the winning priority is less than or equal to the core's 8-bit mask; otherwise it shows 1023.
- R5: A core's request line is 1 only when its pending ID is showing a winner and the winning priority is strictly less than the core's 9-bit running priority; 0x100 means idle and is above every 8-bit priority.
- R6: When `dist_en` is 0, or the core's bit in `core_en` is 0, that core's request line is 0 and its pending ID is 1023.
- R7: Both outputs are registered. They reflect the inputs that were present at the previous rising clock edge. While reset is asserted, every request line is 0 and every pending ID is 1023.
- R8: Each pending ID is 10 bits wide. A value of 1023 means no interrupt; any other value is less than NUM_IRQ.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dist_en | input | 1 | Global enable for the whole controller |
| core_en | input | NUM_CORES | Per-core interface enable |
| irq_enable | input | NUM_CORES*NUM_IRQ | Enable bits, one per interrupt per core |
| irq_pending | input | NUM_CORES*NUM_IRQ | Pending bits, one per interrupt per core |
| prio_private | input | NUM_CORES*32*8 | Per-core priorities for IDs 0 to 31 |
| prio_shared | input | (NUM_IRQ-32)*8 | Shared priorities for IDs 32 and up |
| core_mask | input | NUM_CORES*8 | Per-core priority mask |
| core_run_prio | input | NUM_CORES*9 | Per-core running priority (0x100 when idle) |
| core_irq | output | NUM_CORES | Per-core interrupt request line |
| core_pend_id | output | NUM_CORES*10 | Per-core visible pending ID (1023 when none) |

## Verification
The bench builds the block with three cores and 80 interrupts. Eighty is not a power of two, so the unused padding slots of the reduction tree are exercised, and the range also includes shared IDs above 64. With three cores, private entries can differ across cores while a shared entry is identical everywhere. This lets the bench show that the same private ID can win on one core and be hidden on another. Random patterns with a narrow priority spread create many ties, and directed cases place the winning priority exactly on the mask and exactly on the running priority.

// File: rtl/irqsel_pkg.sv
`timescale 1ns/1ps
package irqsel_pkg;
  localparam int          ID_W      = 10;
  localparam int          PW        = 8;
  localparam int          RPW       = PW + 1;
  localparam int          PRIV_CNT  = 32;
  localparam logic [ID_W-1:0] NO_IRQ    = 10'd1023;
  localparam logic [RPW-1:0]  IDLE_PRIO = 9'h100;

  typedef struct packed {
    logic [RPW-1:0]  prio;
    logic [ID_W-1:0] id;
  } cand_t;

  // left side wins ties, so the lower ID survives
  function automatic cand_t pick_better(input cand_t lo_side, input cand_t hi_side);
    return (lo_side.prio <= hi_side.prio) ? lo_side : hi_side;
  endfunction

  function automatic logic is_visible(input logic [RPW-1:0] best, input logic [PW-1:0] mask);
    return best <= {1'b0, mask};
  endfunction

  function automatic logic beats_running(input logic [RPW-1:0] best, input logic [RPW-1:0] running);
    return best < running;
  endfunction
endpackage

// File: rtl/irqsel_prio_route.sv
`timescale 1ns/1ps
module irqsel_prio_route
  import irqsel_pkg::*;
#(
  parameter int NUM_IRQ = 64,
  localparam int SHARED_CNT = NUM_IRQ - PRIV_CNT
) (
  input  logic [PRIV_CNT*PW-1:0]   own_priv,
  input  logic [SHARED_CNT*PW-1:0] shared_tab,
  output logic [NUM_IRQ*PW-1:0]    prio_vec
);
  for (genvar i = 0; i < NUM_IRQ; i++) begin : g_slot
    if (i < PRIV_CNT) begin : g_priv
      assign prio_vec[i*PW +: PW] = own_priv[i*PW +: PW];
    end else begin : g_shared
      assign prio_vec[i*PW +: PW] = shared_tab[(i-PRIV_CNT)*PW +: PW];
    end
  end
endmodule

// File: rtl/irqsel_min_tree.sv
`timescale 1ns/1ps
module irqsel_min_tree
  import irqsel_pkg::*;
#(
  parameter int NUM_IRQ = 64,
  localparam int LEVELS = $clog2(NUM_IRQ),
  localparam int LEAVES = 1 << LEVELS
) (
  input  logic [NUM_IRQ-1:0]    req,
  input  logic [NUM_IRQ*PW-1:0] prio_vec,
  output cand_t                 best
);
  cand_t node [1:2*LEAVES-1];

  always_comb begin
    for (int l = 0; l < LEAVES; l++) begin
      if (l < NUM_IRQ && req[l]) begin
        node[LEAVES+l].prio = {1'b0, prio_vec[l*PW +: PW]};
        node[LEAVES+l].id   = ID_W'(l);
      end else begin
        node[LEAVES+l].prio = IDLE_PRIO;
        node[LEAVES+l].id   = NO_IRQ;
      end
    end
    for (int n = LEAVES - 1; n >= 1; n--) begin
      node[n] = pick_better(node[2*n], node[2*n+1]);
    end
  end

  assign best = node[1];
endmodule

// File: rtl/irqsel_core_gate.sv
`timescale 1ns/1ps
module irqsel_core_gate
  import irqsel_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            dist_en,
  input  logic            core_on,
  input  logic [PW-1:0]   mask,
  input  logic [RPW-1:0]  run_prio,
  input  cand_t           best,
  output logic            irq_q,
  output logic [ID_W-1:0] id_q
);
  logic           gate_on;
  logic           shown;
  logic           fire;
  logic [RPW-1:0] best_prio;

  assign best_prio = best.prio;
  assign gate_on   = dist_en & core_on;
  assign shown     = gate_on & is_visible(best_prio, mask);
  assign fire      = shown & beats_running(best_prio, run_prio);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      irq_q <= 1'b0;
      id_q  <= NO_IRQ;
    end else begin
      irq_q <= fire;
      id_q  <= shown ? best.id : NO_IRQ;
    end
  end

  AST_IRQ_HAS_ID: assert property (@(posedge clk) disable iff (!rst_n)
    irq_q |-> id_q != NO_IRQ); // R5
  AST_IRQ_STRICT: assert property (@(posedge clk) disable iff (!rst_n)
    irq_q |-> $past(best_prio) < $past(run_prio)); // R5
  AST_GATE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !gate_on |=> (!irq_q && id_q == NO_IRQ)); // R6
  AST_ID_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    id_q != NO_IRQ |-> $past(best_prio) <= {1'b0, $past(mask)}); // R4
endmodule

// File: rtl/irq_prio_select.sv
`timescale 1ns/1ps
module irq_prio_select
  import irqsel_pkg::*;
#(
  parameter int NUM_CORES = 4,
  parameter int NUM_IRQ   = 64,
  localparam int SHARED_CNT = NUM_IRQ - PRIV_CNT
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            dist_en,
  input  logic [NUM_CORES-1:0]            core_en,
  input  logic [NUM_CORES*NUM_IRQ-1:0]    irq_enable,
  input  logic [NUM_CORES*NUM_IRQ-1:0]    irq_pending,
  input  logic [NUM_CORES*PRIV_CNT*PW-1:0] prio_private,
  input  logic [SHARED_CNT*PW-1:0]        prio_shared,
  input  logic [NUM_CORES*PW-1:0]         core_mask,
  input  logic [NUM_CORES*RPW-1:0]        core_run_prio,
  output logic [NUM_CORES-1:0]            core_irq,
  output logic [NUM_CORES*ID_W-1:0]       core_pend_id
);
  localparam logic [ID_W-1:0] ID_LIMIT = ID_W'(NUM_IRQ);

  for (genvar c = 0; c < NUM_CORES; c++) begin : g_core
    logic [NUM_IRQ-1:0]    req_c;
    logic [NUM_IRQ*PW-1:0] prio_c;
    cand_t                 best_c;
    logic [ID_W-1:0]       id_c;
    logic [NUM_IRQ-1:0]    req_d;
    logic                  win_was_req;

    assign req_c = irq_enable[c*NUM_IRQ +: NUM_IRQ] & irq_pending[c*NUM_IRQ +: NUM_IRQ];

    irqsel_prio_route #(.NUM_IRQ(NUM_IRQ)) u_route (
      .own_priv  (prio_private[c*PRIV_CNT*PW +: PRIV_CNT*PW]),
      .shared_tab(prio_shared),
      .prio_vec  (prio_c)
    );

    irqsel_min_tree #(.NUM_IRQ(NUM_IRQ)) u_tree (
      .req     (req_c),
      .prio_vec(prio_c),
      .best    (best_c)
    );

    irqsel_core_gate u_gate (
      .clk     (clk),
      .rst_n   (rst_n),
      .dist_en (dist_en),
      .core_on (core_en[c]),
      .mask    (core_mask[c*PW +: PW]),
      .run_prio(core_run_prio[c*RPW +: RPW]),
      .best    (best_c),
      .irq_q   (core_irq[c]),
      .id_q    (id_c)
    );

    assign core_pend_id[c*ID_W +: ID_W] = id_c;

    // delayed request view used only to relate the shown ID to its source
    always_ff @(posedge clk) begin
      if (!rst_n) req_d <= '0;
      else        req_d <= req_c;
    end

    always_comb begin
      win_was_req = 1'b0;
      for (int i = 0; i < NUM_IRQ; i++) begin
        if (id_c == ID_W'(i) && req_d[i]) win_was_req = 1'b1;
      end
    end

    AST_ID_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      id_c != NO_IRQ |-> id_c < ID_LIMIT); // R8
    AST_WIN_REQUESTED: assert property (@(posedge clk) disable iff (!rst_n)
      id_c != NO_IRQ |-> win_was_req); // R3
  end
endmodule

// File: tb/irq_prio_select_tb_top.sv
`timescale 1ns/1ps
module irq_prio_select_tb_top;
  localparam int NC = 3;
  localparam int NI = 80;
  localparam int NS = NI - 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  bit         de;
  bit [NC-1:0] ce;
  bit         en_b [NC][NI];
  bit         pe_b [NC][NI];
  bit [7:0]   ppriv [NC][32];
  bit [7:0]   psh [NS];
  bit [7:0]   msk [NC];
  bit [8:0]   run [NC];

  logic [NC*NI-1:0]   irq_enable, irq_pending;
  logic [NC*32*8-1:0] prio_private;
  logic [NS*8-1:0]    prio_shared;
  logic [NC*8-1:0]    core_mask;
  logic [NC*9-1:0]    core_run_prio;
  logic [NC-1:0]      core_irq;
  logic [NC*10-1:0]   core_pend_id;

  always_comb begin
    for (int c = 0; c < NC; c++) begin
      for (int i = 0; i < NI; i++) begin
        irq_enable[c*NI+i]  = en_b[c][i];
        irq_pending[c*NI+i] = pe_b[c][i];
      end
      for (int i = 0; i < 32; i++) prio_private[(c*32+i)*8 +: 8] = ppriv[c][i];
      core_mask[c*8 +: 8]    = msk[c];
      core_run_prio[c*9 +: 9] = run[c];
    end
    for (int i = 0; i < NS; i++) prio_shared[i*8 +: 8] = psh[i];
  end

  irq_prio_select #(.NUM_CORES(NC), .NUM_IRQ(NI)) dut_i (
    .clk(clk), .rst_n(rst_n), .dist_en(de), .core_en(ce),
    .irq_enable(irq_enable), .irq_pending(irq_pending),
    .prio_private(prio_private), .prio_shared(prio_shared),
    .core_mask(core_mask), .core_run_prio(core_run_prio),
    .core_irq(core_irq), .core_pend_id(core_pend_id)
  );

  int total = 0;
  int fails = 0;
  int exp_irq [NC];
  int exp_id  [NC];

  // behavioural reference: plain linear search per core
  task automatic predict();
    for (int c = 0; c < NC; c++) begin
      int best = 256;
      int bid = 1023;
      for (int i = 0; i < NI; i++) begin
        if (en_b[c][i] && pe_b[c][i]) begin
          int p = (i < 32) ? int'(ppriv[c][i]) : int'(psh[i-32]);
          if (p < best) begin best = p; bid = i; end
        end
      end
      if (de && ce[c] && best <= int'(msk[c])) begin
        exp_id[c]  = bid;
        exp_irq[c] = (best < int'(run[c])) ? 1 : 0;
      end else begin
        exp_id[c]  = 1023;
        exp_irq[c] = 0;
      end
    end
  endtask

  task automatic compare(input string tag);
    for (int c = 0; c < NC; c++) begin
      total++;
      if (int'(core_irq[c]) != exp_irq[c]) begin
        fails++;
        $display("FAIL %s core %0d irq: actual %0d expected %0d", tag, c, core_irq[c], exp_irq[c]);
      end
      total++;
      if (int'(core_pend_id[c*10 +: 10]) != exp_id[c]) begin
        fails++;
        $display("FAIL %s core %0d id: actual %0d expected %0d", tag, c, core_pend_id[c*10 +: 10], exp_id[c]);
      end
    end
  endtask

  // inputs are set at a falling edge; outputs checked at the next falling edge
  task automatic step(input string tag);
    predict();
    @(posedge clk);
    @(negedge clk);
    compare(tag);
  endtask

  task automatic expect_id(input string tag, input int c, input int id, input int irq);
    total++;
    if (exp_id[c] != id || exp_irq[c] != irq) begin
      fails++;
      $display("FAIL %s model core %0d: actual id %0d irq %0d expected id %0d irq %0d",
               tag, c, exp_id[c], exp_irq[c], id, irq);
    end
  endtask

  task automatic clear_all();
    for (int c = 0; c < NC; c++)
      for (int i = 0; i < NI; i++) begin en_b[c][i] = 0; pe_b[c][i] = 0; end
  endtask

  initial begin
    de = 0; ce = '0;
    clear_all();
    for (int c = 0; c < NC; c++) begin
      msk[c] = 8'hF0; run[c] = 9'h100;
      for (int i = 0; i < 32; i++) ppriv[c][i] = 8'h80;
    end
    for (int i = 0; i < NS; i++) psh[i] = 8'h80;

    // R7: reset state
    repeat (3) @(posedge clk);
    @(negedge clk);
    for (int c = 0; c < NC; c++) begin exp_irq[c] = 0; exp_id[c] = 1023; end
    en_b[0][40] = 1; pe_b[0][40] = 1; de = 1; ce = '1;
    @(posedge clk); @(negedge clk);
    compare("R7 reset");
    rst_n = 1'b1;
    step("R7 first cycle");
    expect_id("R7", 0, 40, 1);

    // R6: global and per-core enables
    de = 0;
    step("R6 global off");
    de = 1; ce[0] = 0;
    step("R6 core off");
    expect_id("R6", 0, 1023, 0);
    ce = '1;

    // R1: ties and lowest value
    clear_all();
    psh[40-32] = 8'h20; psh[50-32] = 8'h20;
    en_b[0][50] = 1; pe_b[0][50] = 1; en_b[0][40] = 1; pe_b[0][40] = 1;
    step("R1 tie");
    expect_id("R1", 0, 40, 1);
    ppriv[0][5] = 8'h30; en_b[0][5] = 1; pe_b[0][5] = 1;
    psh[70-32] = 8'h10; en_b[0][70] = 1; pe_b[0][70] = 1;
    step("R1 lowest value");
    expect_id("R1", 0, 70, 1);

    // R2: private per core versus shared
    clear_all();
    msk[0] = 8'h40; msk[1] = 8'h40;
    ppriv[0][3] = 8'h10; ppriv[1][3] = 8'h80;
    en_b[0][3] = 1; pe_b[0][3] = 1; en_b[1][3] = 1; pe_b[1][3] = 1;
    step("R2 private");
    expect_id("R2", 0, 3, 1);
    expect_id("R2", 1, 1023, 0);
    psh[33-32] = 8'h11;
    en_b[1][33] = 1; pe_b[1][33] = 1; en_b[2][33] = 1; pe_b[2][33] = 1;
    step("R2 shared");
    expect_id("R2", 1, 33, 1);

    // R3: only enabled and pending interrupts compete
    clear_all();
    msk[0] = 8'hF0;
    psh[60-32] = 8'h01; en_b[0][60] = 1;
    psh[61-32] = 8'h02; pe_b[0][61] = 1;
    en_b[1][60] = 1; pe_b[1][60] = 1;
    psh[62-32] = 8'h50; en_b[0][62] = 1; pe_b[0][62] = 1;
    step("R3 filter");
    expect_id("R3", 0, 62, 1);

    // R4: mask boundary
    clear_all();
    psh[45-32] = 8'h60; en_b[2][45] = 1; pe_b[2][45] = 1;
    msk[2] = 8'h60;
    step("R4 equal mask");
    expect_id("R4", 2, 45, 1);
    msk[2] = 8'h5F;
    step("R4 above mask");
    expect_id("R4", 2, 1023, 0);

    // R5: running priority strictness
    msk[2] = 8'hFF; run[2] = 9'h060;
    step("R5 equal running");
    expect_id("R5", 2, 45, 0);
    run[2] = 9'h061;
    step("R5 below running");
    expect_id("R5", 2, 45, 1);
    psh[45-32] = 8'hFF; run[2] = 9'h100;
    step("R5 idle running");
    expect_id("R5", 2, 45, 1);

    // R8 / R1: random patterns with frequent ties
    for (int n = 0; n < 400; n++) begin
      int spread = (n % 3 == 0) ? 4 : 256;
      for (int c = 0; c < NC; c++) begin
        for (int i = 0; i < NI; i++) begin
          en_b[c][i] = ($urandom % 4) != 0;
          pe_b[c][i] = ($urandom % 8) == 0;
        end
        for (int i = 0; i < 32; i++) ppriv[c][i] = 8'($urandom % spread);
        msk[c] = 8'($urandom);
        run[c] = ($urandom % 5 == 0) ? 9'h100 : 9'($urandom % 256);
      end
      for (int i = 0; i < NS; i++) psh[i] = 8'($urandom % spread);
      de = ($urandom % 16) != 0;
      ce = NC'($urandom | 32'h6);
      step("R8 random");
    end

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    total++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule